// File: doc/BRIEF.md
# VME A24/D16 Slave Cycle Controller

This block sits between a VME backplane and a card's local register bus. It watches the backplane's address, address-modifier and strobe lines and waits for a standard 24-bit address, 16-bit data access aimed at this card. When such a cycle arrives, it drives a local bus toward the on-card devices: one active-low chip select out of 32, an 8-bit register address, a direction line and a write strobe. It acknowledges the master with an active-low DTACK. It also enables the data transceivers during the data phase. A cycle whose address strobe ends before any data strobe arrives goes to an error state and produces a one-clock error pulse.

All backplane inputs are asynchronous. Each one passes through a synchronizer before it reaches the decode and sequencing logic. The address fields are held in a capture register that stops updating once the data phase begins. Between cycles the local bus sits at fixed idle values, and the idle-data driver presents the interrupter Status/ID word.

Top module: `vme_slave_seq`

## Requirements
- R1: After rst_ni deasserts, all 32 chip selects are high, the register address is 0, dir_o is 0, the write strobe and DTACK are high, the latch enable is high, board select is low and no error pulse is present.
- R2: A cycle is claimed only when all of these hold: AS low, IACK high, LWORD high, A23..A21 zero, A20..A15 equal to card_addr_i, and A9 zero. The modifier must also be one of the accepted codes in R11. If any of them fails, no chip select falls and DTACK stays high.
- R3: During a claimed cycle exactly one chip select is low, at index A14..A10, and reg_addr_o equals A8..A1.
- R4: A write cycle (WRITE low) has dir_o at 0 and holds wr_strobe_no low for exactly one clock before DTACK falls.
- R5: A read cycle (WRITE high) has dir_o at 1 and never asserts the write strobe.
- R6: DTACK stays low while either data strobe or AS is still low. It returns high within a few clocks after all three are high.
- R7: If AS rises before both data strobes have fallen, err_pulse_o is high for exactly one clock. That cycle produces no DTACK and no write strobe.
- R8: Once the data phase has begun (latch enable low), address changes on the backplane do not alter the chip select or the register address.
- R9: SYSRESET low forces the idle state from any state, even while AS and the data strobes are still low.
- R10: idle_data_en_o is high only in the idle state, and idle_data_o always equals status_id_i.
- R11: Each of the address-modifier codes 0x39, 0x3A, 0x3D and 0x3E is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sysreset_ni | input | 1 | Backplane system reset, active low, asynchronous |
| as_ni | input | 1 | Address strobe, active low |
| ds_ni | input | 2 | Data strobes, active low |
| write_ni | input | 1 | Low for write cycles |
| iack_ni | input | 1 | Interrupt acknowledge, active low |
| lword_ni | input | 1 | Long-word select, active low |
| am_i | input | 6 | Address modifier |
| addr_i | input | 23 | Address lines A23..A1 |
| card_addr_i | input | 6 | Card address from the board switches |
| status_id_i | input | 16 | Interrupter Status/ID word for the idle data bus |
| cs_no | output | 32 | Active-low one-hot chip selects |
| reg_addr_o | output | 8 | Local register address |
| dir_o | output | 1 | 1 for read, 0 for write |
| wr_strobe_no | output | 1 | Local write strobe, active low |
| dtack_no | output | 1 | Data acknowledge, active low |
| xcvr_en_no | output | 1 | Data transceiver enable, active low |
| board_sel_o | output | 1 | High while this card owns a cycle |
| ale_o | output | 1 | Address capture enable |
| err_pulse_o | output | 1 | One-clock pulse for a cycle without a data phase |
| idle_data_en_o | output | 1 | Enables the idle driver on the local data bus |
| idle_data_o | output | 16 | Idle value for the local data bus |

## Verification
The hardest paths to reach are the ones where the master breaks the normal ordering. In one, AS rises while the data strobes are still high. In another, the address lines change in the middle of an acknowledged cycle. In a third, SYSRESET arrives while the master still holds its strobes low. The driver task handles each of these with its own mode. It holds AS low long enough for the synchronizer and the capture register to claim the cycle. It then releases AS alone, or alters the address while DTACK is low, or pulls the system reset while the cycle is held open. The monitor records chip select, register address, strobe count and error pulses for each cycle and compares them against the expected item.

// File: rtl/vme_slave_pkg.sv
package vme_slave_pkg;
  localparam int VME_AW   = 24;
  localparam int AM_W     = 6;
  localparam int CARD_AW  = 6;
  localparam int CHIP_AW  = 5;
  localparam int REG_AW   = 8;
  localparam int N_CHIP   = 1 << CHIP_AW;
  // bit positions of the address fields (byte address, A0 not carried)
  localparam int REG_LSB  = 1;
  localparam int RSV_BIT  = REG_LSB + REG_AW;
  localparam int CHIP_LSB = RSV_BIT + 1;
  localparam int CARD_LSB = CHIP_LSB + CHIP_AW;
  localparam int TOP_LSB  = CARD_LSB + CARD_AW;
  localparam int TOP_W    = VME_AW - TOP_LSB;

  typedef enum logic [2:0] {
    ST_IDLE, ST_WAKE, ST_ERR, ST_BEGIN, ST_STROBE, ST_RDWAIT, ST_ACK
  } cyc_state_e;

  typedef struct packed {
    logic              write_n;
    logic              iack_n;
    logic              lword_n;
    logic [AM_W-1:0]   am;
    logic [VME_AW-1:1] addr;
  } vme_fields_t;

  localparam int FIELDS_W = $bits(vme_fields_t);

  function automatic logic am_is_a24(input logic [AM_W-1:0] am);
    return (am == 6'h39) || (am == 6'h3A) || (am == 6'h3D) || (am == 6'h3E);
  endfunction
endpackage

// File: rtl/vme_sync.sv
module vme_sync #(
  parameter int           W       = 1,
  parameter int           STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= RST_VAL;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/vme_addr_dec.sv
module vme_addr_dec
  import vme_slave_pkg::*;
(
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     ale_i,
  input  logic                     as_n_i,
  input  vme_fields_t              fields_i,
  input  logic [CARD_AW-1:0]       card_addr_i,
  output logic                     match_o,
  output logic [CHIP_AW-1:0]       chip_o,
  output logic [REG_AW-1:0]        reg_o,
  output logic                     write_n_o
);
  vme_fields_t lat_q;

  localparam vme_fields_t LAT_RST = '{write_n: 1'b1, iack_n: 1'b1, lword_n: 1'b1,
                                      am: '0, addr: '0};

  // capture is transparent-per-clock while enabled, frozen for the data phase
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    lat_q <= LAT_RST;
    else if (ale_i) lat_q <= fields_i;
  end

  logic top_zero, card_hit, rsv_zero;
  assign top_zero = (lat_q.addr[VME_AW-1:TOP_LSB] == '0);
  assign card_hit = (lat_q.addr[TOP_LSB-1:CARD_LSB] == card_addr_i);
  assign rsv_zero = !lat_q.addr[RSV_BIT];

  assign match_o   = !as_n_i && lat_q.iack_n && lat_q.lword_n && am_is_a24(lat_q.am)
                     && top_zero && card_hit && rsv_zero;
  assign chip_o    = lat_q.addr[CARD_LSB-1:CHIP_LSB];
  assign reg_o     = lat_q.addr[RSV_BIT-1:REG_LSB];
  assign write_n_o = lat_q.write_n;
endmodule

// File: rtl/vme_cs_gen.sv
module vme_cs_gen #(
  parameter int IDX_W = 5,
  parameter int N     = 1 << IDX_W
) (
  input  logic             en_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic [N-1:0]     cs_no
);
  for (genvar g = 0; g < N; g++) begin : g_cs
    assign cs_no[g] = !(en_i && (idx_i == IDX_W'(g)));
  end
endmodule

// File: rtl/vme_cyc_fsm.sv
module vme_cyc_fsm
  import vme_slave_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sysreset_n_i,
  input  logic       as_n_i,
  input  logic [1:0] ds_n_i,
  input  logic       match_i,
  input  logic       write_n_i,
  output cyc_state_e state_o,
  output logic       board_sel_o,
  output logic       ale_o,
  output logic       dir_o,
  output logic       wr_strobe_no,
  output logic       dtack_no,
  output logic       xcvr_en_no,
  output logic       err_pulse_o,
  output logic       idle_o
);
  cyc_state_e st_q, st_d;

  logic ds_both_low, all_released;
  assign ds_both_low  = (ds_n_i == 2'b00);
  assign all_released = as_n_i && (ds_n_i == 2'b11);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:   if (match_i) st_d = ST_WAKE;
      ST_WAKE: begin
        if (as_n_i)           st_d = ST_ERR;
        else if (ds_both_low) st_d = ST_BEGIN;
      end
      ST_ERR:    st_d = ST_IDLE;
      ST_BEGIN:  st_d = write_n_i ? ST_RDWAIT : ST_STROBE;
      ST_STROBE: st_d = ST_ACK;
      ST_RDWAIT: st_d = ST_ACK;
      ST_ACK:    if (all_released) st_d = ST_IDLE;
      default:   st_d = ST_IDLE;
    endcase
    if (!sysreset_n_i) st_d = ST_IDLE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_d;
  end

  logic data_phase;
  assign data_phase = (st_q == ST_BEGIN) || (st_q == ST_STROBE) ||
                      (st_q == ST_RDWAIT) || (st_q == ST_ACK);

  assign state_o      = st_q;
  assign idle_o       = (st_q == ST_IDLE);
  assign board_sel_o  = (st_q == ST_WAKE) || data_phase;
  assign ale_o        = !data_phase;
  assign dir_o        = data_phase && write_n_i;
  assign wr_strobe_no = (st_q != ST_STROBE);
  assign dtack_no     = (st_q != ST_ACK);
  assign xcvr_en_no   = !data_phase;
  assign err_pulse_o  = (st_q == ST_ERR);
endmodule

// File: rtl/vme_slave_seq.sv
module vme_slave_seq
  import vme_slave_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int DATA_W      = 16
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   sysreset_ni,
  input  logic                   as_ni,
  input  logic [1:0]             ds_ni,
  input  logic                   write_ni,
  input  logic                   iack_ni,
  input  logic                   lword_ni,
  input  logic [AM_W-1:0]        am_i,
  input  logic [VME_AW-1:1]      addr_i,
  input  logic [CARD_AW-1:0]     card_addr_i,
  input  logic [DATA_W-1:0]      status_id_i,
  output logic [N_CHIP-1:0]      cs_no,
  output logic [REG_AW-1:0]      reg_addr_o,
  output logic                   dir_o,
  output logic                   wr_strobe_no,
  output logic                   dtack_no,
  output logic                   xcvr_en_no,
  output logic                   board_sel_o,
  output logic                   ale_o,
  output logic                   err_pulse_o,
  output logic                   idle_data_en_o,
  output logic [DATA_W-1:0]      idle_data_o
);
  localparam int CTL_W = 4;

  logic [CTL_W-1:0] ctl_s;
  vme_fields_t      fld_raw, fld_s;

  vme_sync #(.W(CTL_W), .STAGES(SYNC_STAGES), .RST_VAL({CTL_W{1'b1}})) u_sync_ctl (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({sysreset_ni, as_ni, ds_ni}),
    .q_o   (ctl_s)
  );

  assign fld_raw = '{write_n: write_ni, iack_n: iack_ni, lword_n: lword_ni,
                     am: am_i, addr: addr_i};

  vme_sync #(.W(FIELDS_W), .STAGES(SYNC_STAGES),
             .RST_VAL({3'b111, {(FIELDS_W-3){1'b0}}})) u_sync_fld (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (fld_raw),
    .q_o   (fld_s)
  );

  logic sysreset_n_s, as_n_s;
  logic [1:0] ds_n_s;
  assign {sysreset_n_s, as_n_s, ds_n_s} = ctl_s;

  logic               match, write_n_l, idle;
  logic [CHIP_AW-1:0] chip_idx;
  logic [REG_AW-1:0]  reg_idx;
  cyc_state_e         state;

  vme_addr_dec u_dec (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ale_i      (ale_o),
    .as_n_i     (as_n_s),
    .fields_i   (fld_s),
    .card_addr_i(card_addr_i),
    .match_o    (match),
    .chip_o     (chip_idx),
    .reg_o      (reg_idx),
    .write_n_o  (write_n_l)
  );

  vme_cyc_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sysreset_n_i(sysreset_n_s),
    .as_n_i      (as_n_s),
    .ds_n_i      (ds_n_s),
    .match_i     (match),
    .write_n_i   (write_n_l),
    .state_o     (state),
    .board_sel_o (board_sel_o),
    .ale_o       (ale_o),
    .dir_o       (dir_o),
    .wr_strobe_no(wr_strobe_no),
    .dtack_no    (dtack_no),
    .xcvr_en_no  (xcvr_en_no),
    .err_pulse_o (err_pulse_o),
    .idle_o      (idle)
  );

  vme_cs_gen #(.IDX_W(CHIP_AW), .N(N_CHIP)) u_cs (
    .en_i (board_sel_o),
    .idx_i(chip_idx),
    .cs_no(cs_no)
  );

  assign reg_addr_o     = board_sel_o ? reg_idx : '0;
  assign idle_data_en_o = idle;
  assign idle_data_o    = status_id_i;
endmodule

// File: rtl/vme_slave_seq_chk.sv
module vme_slave_seq_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [31:0] cs_no,
  input logic [7:0]  reg_addr_o,
  input logic        dir_o,
  input logic        wr_strobe_no,
  input logic        dtack_no,
  input logic        xcvr_en_no,
  input logic        board_sel_o,
  input logic        ale_o,
  input logic        err_pulse_o,
  input logic        idle_data_en_o
);
  a_r3_cs_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~cs_no));

  a_r3_sel_has_cs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    board_sel_o |-> ($countones(~cs_no) == 1));

  a_r4_strobe_one_clk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_strobe_no |=> wr_strobe_no);

  a_r4_strobe_write_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_strobe_no |-> (!dir_o && dtack_no && !(&cs_no)));

  a_r5_read_no_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dir_o |-> wr_strobe_no);

  a_r6_ack_in_data_phase: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dtack_no |-> (!ale_o && !xcvr_en_no && board_sel_o));

  a_r7_err_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_pulse_o |=> !err_pulse_o);

  a_r7_err_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_pulse_o |-> (dtack_no && wr_strobe_no && (&cs_no)));

  a_r8_frozen_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ale_o && $past(!ale_o)) |-> ($stable(cs_no) && $stable(reg_addr_o)));

  a_r10_idle_values: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_data_en_o |-> ((&cs_no) && reg_addr_o == 8'h00 && !dir_o && wr_strobe_no
                        && dtack_no && ale_o && xcvr_en_no));
endmodule

bind vme_slave_seq vme_slave_seq_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .cs_no         (cs_no),
  .reg_addr_o    (reg_addr_o),
  .dir_o         (dir_o),
  .wr_strobe_no  (wr_strobe_no),
  .dtack_no      (dtack_no),
  .xcvr_en_no    (xcvr_en_no),
  .board_sel_o   (board_sel_o),
  .ale_o         (ale_o),
  .err_pulse_o   (err_pulse_o),
  .idle_data_en_o(idle_data_en_o)
);

// File: tb/vme_slave_seq_test.sv
module vme_slave_seq_test;
  localparam int K_SKIP = 0, K_WR = 1, K_RD = 2, K_NONE = 3, K_ERR = 4;
  localparam int M_NORM = 0, M_ABORT = 1, M_SHIFT = 2;
  localparam logic [5:0]  CARD = 6'h0D;
  localparam logic [15:0] SID  = 16'hA5C3;

  typedef struct {
    int    kind;
    int    chip;
    int    rg;
    string req;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n, sysrst_n, as_n, write_n, iack_n, lword_n;
  logic [1:0]  ds_n;
  logic [5:0]  am;
  logic [23:1] addr;
  logic [31:0] cs_n;
  logic [7:0]  reg_addr;
  logic dir, wstb_n, dtack_n, xcvr_n, bsel, ale, err, idle_en;
  logic [15:0] idle_data;

  always #10 clk = ~clk;

  vme_slave_seq uut (
    .clk_i(clk), .rst_ni(rst_n), .sysreset_ni(sysrst_n), .as_ni(as_n), .ds_ni(ds_n),
    .write_ni(write_n), .iack_ni(iack_n), .lword_ni(lword_n), .am_i(am), .addr_i(addr),
    .card_addr_i(CARD), .status_id_i(SID), .cs_no(cs_n), .reg_addr_o(reg_addr),
    .dir_o(dir), .wr_strobe_no(wstb_n), .dtack_no(dtack_n), .xcvr_en_no(xcvr_n),
    .board_sel_o(bsel), .ale_o(ale), .err_pulse_o(err), .idle_data_en_o(idle_en),
    .idle_data_o(idle_data)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0, cyc_end = 0;
  exp_t q[$];

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [23:1] mk(input logic [5:0] card, input int chip, input int rg);
    logic [23:0] b;
    b = {3'b000, card, 5'(chip), 1'b0, 8'(rg), 1'b0};
    return b[23:1];
  endfunction

  // monitor accumulators
  bit m_dtack, m_sel, m_frz_bad, m_idle_bad;
  int m_err, m_stb, m_cs, m_reg, m_dir;
  logic [31:0] m_cs_first;
  logic [7:0]  m_reg_first;

  task automatic m_clear();
    m_dtack = 0; m_sel = 0; m_frz_bad = 0; m_idle_bad = 0;
    m_err = 0; m_stb = 0; m_cs = -1; m_reg = -1; m_dir = -1;
  endtask

  initial m_clear();

  always @(negedge clk) begin
    if (rst_n) begin
      if (cyc_end) begin
        exp_t e;
        e = q.pop_front();
        case (e.kind)
          K_WR, K_RD: begin
            chk(m_dtack, e.req, "dtack seen", m_dtack, 1);
            chk(m_cs == e.chip, "R3", "chip select index", m_cs, e.chip);
            chk(m_reg == e.rg, "R3", "register address", m_reg, e.rg);
            chk(m_dir == (e.kind == K_RD), e.kind == K_RD ? "R5" : "R4", "direction",
                m_dir, e.kind == K_RD);
            chk(m_stb == (e.kind == K_WR), e.kind == K_RD ? "R5" : "R4",
                "strobe clocks", m_stb, e.kind == K_WR);
            chk(!m_frz_bad, "R8", "address held in data phase", m_frz_bad, 0);
            chk(!m_idle_bad, "R10", "idle driver off in cycle", m_idle_bad, 0);
          end
          K_NONE: begin
            chk(!m_sel, e.req, "no chip select", m_sel, 0);
            chk(!m_dtack, e.req, "no dtack", m_dtack, 0);
          end
          K_ERR: begin
            chk(m_err == 1, "R7", "error pulse clocks", m_err, 1);
            chk(!m_dtack, "R7", "no dtack on error", m_dtack, 0);
            chk(m_stb == 0, "R7", "no strobe on error", m_stb, 0);
          end
          default: ;
        endcase
        m_clear();
        cyc_end = 0;
      end else begin
        if (!(&cs_n)) m_sel = 1;
        if (err) m_err++;
        if (!wstb_n) m_stb++;
        if (bsel && idle_en) m_idle_bad = 1;
        if (!dtack_n) begin
          if (!m_dtack) begin
            m_dtack = 1;
            m_cs_first = cs_n;
            m_reg_first = reg_addr;
            m_reg = reg_addr;
            m_dir = dir;
            for (int i = 0; i < 32; i++) if (!cs_n[i]) m_cs = i;
          end else if (cs_n != m_cs_first || reg_addr != m_reg_first) begin
            m_frz_bad = 1;
          end
        end
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic run_cycle(input logic [23:1] a, input logic [5:0] amv, input bit wr,
                           input bit iackv, input bit lwv, input int mode,
                           input int kind, input int chip, input int rg, input string req);
    exp_t e;
    bit seen;
    e.kind = kind; e.chip = chip; e.rg = rg; e.req = req;
    q.push_back(e);
    addr = a; am = amv; write_n = !wr; iack_n = iackv; lword_n = lwv;
    tick(3);
    as_n = 1'b0;
    if (mode == M_ABORT) begin
      tick(6);
      as_n = 1'b1;
    end else begin
      tick(3);
      ds_n = 2'b00;
      seen = 0;
      for (int i = 0; i < 20 && !seen; i++) begin
        @(negedge clk);
        if (!dtack_n) seen = 1;
      end
      tick(1);
      if (seen) begin
        if (mode == M_SHIFT) begin
          addr = mk(CARD, 9, 8'h5A) ^ 23'h7FFFFF;
          write_n = !write_n;
        end
        tick(4);
        ds_n = 2'b11;
        tick(6);
        chk(!dtack_n, "R6", "dtack held while AS low", dtack_n, 0);
        as_n = 1'b1;
        tick(4);
        chk(dtack_n, "R6", "dtack released", dtack_n, 1);
      end else begin
        ds_n = 2'b11;
        as_n = 1'b1;
      end
    end
    tick(6);
    cyc_end = 1;
    tick(2);
  endtask

  initial begin
    rst_n = 0; sysrst_n = 1; as_n = 1; ds_n = 2'b11; write_n = 1;
    iack_n = 1; lword_n = 1; am = 6'h39; addr = '0;
    tick(3);
    rst_n = 1;
    @(negedge clk);
    chk(&cs_n, "R1", "chip selects idle", cs_n, 32'hFFFFFFFF);
    chk(reg_addr == 0, "R1", "register address idle", reg_addr, 0);
    chk(!dir && wstb_n && dtack_n, "R1", "dir/strobe/dtack", {dir, wstb_n, dtack_n}, 3'b011);
    chk(ale && !bsel && !err, "R1", "ale/bsel/err", {ale, bsel, err}, 3'b100);
    chk(idle_en && idle_data == SID, "R10", "idle data", idle_data, SID);
    tick(1);

    run_cycle(mk(CARD, 3, 8'h12), 6'h39, 1, 1, 1, M_NORM, K_WR, 3, 8'h12, "R11");
    run_cycle(mk(CARD, 17, 8'hFF), 6'h3A, 0, 1, 1, M_NORM, K_RD, 17, 8'hFF, "R11");
    run_cycle(mk(CARD, 0, 8'h00), 6'h3D, 1, 1, 1, M_NORM, K_WR, 0, 8'h00, "R11");
    run_cycle(mk(CARD, 31, 8'h80), 6'h3E, 0, 1, 1, M_SHIFT, K_RD, 31, 8'h80, "R8");
    run_cycle(mk(CARD, 6, 8'h44), 6'h3D, 1, 1, 1, M_SHIFT, K_WR, 6, 8'h44, "R8");
    run_cycle(mk(CARD, 5, 8'h01), 6'h09, 1, 1, 1, M_NORM, K_NONE, 0, 0, "R2 bad modifier");
    run_cycle(mk(CARD, 5, 8'h01), 6'h39, 1, 0, 1, M_NORM, K_NONE, 0, 0, "R2 iack low");
    run_cycle(mk(CARD, 5, 8'h01), 6'h39, 1, 1, 0, M_NORM, K_NONE, 0, 0, "R2 lword low");
    run_cycle(mk(CARD, 5, 8'h01) | 23'h400000, 6'h39, 0, 1, 1, M_NORM, K_NONE, 0, 0,
              "R2 upper bits");
    run_cycle(mk(6'h0E, 5, 8'h01), 6'h39, 0, 1, 1, M_NORM, K_NONE, 0, 0, "R2 card mismatch");
    run_cycle(mk(CARD, 5, 8'h01) | 23'h000100, 6'h39, 1, 1, 1, M_NORM, K_NONE, 0, 0,
              "R2 A9 set");
    run_cycle(mk(CARD, 12, 8'h33), 6'h39, 1, 1, 1, M_ABORT, K_ERR, 0, 0, "R7");
    run_cycle(mk(CARD, 12, 8'h34), 6'h3A, 0, 1, 1, M_NORM, K_RD, 12, 8'h34, "R7 recovery");

    // R9: system reset while the master holds the cycle open
    begin
      exp_t e;
      e.kind = K_SKIP; e.chip = 0; e.rg = 0; e.req = "R9";
      q.push_back(e);
      addr = mk(CARD, 20, 8'h77); am = 6'h39; write_n = 0;
      tick(3);
      as_n = 0;
      tick(3);
      ds_n = 2'b00;
      tick(8);
      @(negedge clk);
      chk(!dtack_n, "R9", "cycle active before reset", dtack_n, 0);
      tick(1);
      sysrst_n = 0;
      tick(4);
      @(negedge clk);
      chk(dtack_n && (&cs_n) && !bsel, "R9", "forced idle", {dtack_n, bsel}, 2'b10);
      chk(idle_en, "R10", "idle driver on after forced idle", idle_en, 1);
      tick(1);
      ds_n = 2'b11; as_n = 1;
      tick(4);
      sysrst_n = 1;
      tick(4);
      cyc_end = 1;
      tick(2);
    end

    @(negedge clk);
    chk(idle_en && idle_data == SID, "R10", "idle data at end", idle_data, SID);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end
endmodule